// File: doc/BRIEF.md
# Mask-Driven Bit Gather/Scatter Engine

This block moves bits between the positions chosen by a selector mask and a packed run of low-order positions. In gather mode it takes the source bits that sit under set mask bits, lowest first, and packs them into the bottom of the result. In scatter mode it does the reverse: it takes the low-order source bits in ascending order and places them at the set mask positions. Every result bit that receives nothing is zero.

The engine is sequential. It visits one mask position per clock and keeps a running count of how many mask bits it has met so far. A caller presents operands, a mode select and a width select together with a one-cycle start strobe. The engine then reports busy for one cycle per operand bit, raises done for a single cycle, and keeps the result until the next accepted start. Operands may be 32 or 64 bits wide. In the narrow width the upper half of the source and mask is disregarded.

Top module: `bitpack_unit`

## Requirements
- R1: While rst_n is low, and after it is released, busy_o and done_o are 0 and result_o is all zeros.
- R2: A start_i that arrives while busy_o is high is ignored. The running operation finishes on its original schedule and returns its own result.
- R3: A start_i seen with busy_o low is accepted. busy_o is then high for exactly N cycles, where N is 32 when wide_i=0 and 64 when wide_i=1. done_o is high for the single cycle that follows, and busy_o is low in that cycle.
- R4: With op_i=0 (gather), result bit k is the source bit under the (k+1)-th lowest set mask bit. All result bits at or above the mask's population count are 0.
- R5: With op_i=1 (scatter), the result bit at the (k+1)-th lowest set mask position is source bit k. Result bits where the mask is 0 are 0.
- R6: With wide_i=0, source and mask bits 63..32 have no effect and result bits 63..32 are 0. As examples, gather with mask 0xff00fff0 and source 0x12345678 gives 0x00012567, and scatter with mask 0xff00fff0 and source 0x00012567 gives 0x12005670.
- R7: An all-zero mask gives a zero result in both modes. An all-ones mask gives the source limited to the selected width.
- R8: After done_o, result_o holds its value until the next accepted start, whatever the data inputs do.
- R9: Source, mask, mode and width are captured on the accepted start. Changing them while busy_o is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start strobe; it is taken only when busy_o is low |
| op_i | input | 1 | 0 = gather (extract), 1 = scatter (deposit) |
| wide_i | input | 1 | 0 = 32-bit operands, 1 = 64-bit operands |
| src_i | input | 64 | Source word |
| mask_i | input | 64 | Selector mask |
| busy_o | output | 1 | High while mask positions are being walked |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| result_o | output | 64 | Result, held until the next accepted start |

## Verification
The directed tests feed the two narrow examples with junk in the upper halves of source and mask. A design that forgets the width select leaks upper mask bits into the packed count and returns a wrong or non-zero upper word. Sparse, dense, all-zero and all-ones masks at both widths catch an engine that swaps the read and write pointers between gather and scatter, or that fails to clear bits that receive nothing. Busy and done are counted edge by edge, so an off-by-one in the walk length or a done pulse longer than one cycle shows up directly. Further tests fire a second start in mid-run, alter the inputs after acceptance and after completion, and assert reset mid-operation. These expose an engine that re-arms while running, reads live inputs, or lets its result drift.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bp_state_e;

  typedef enum logic {
    OP_GATHER  = 1'b0,
    OP_SCATTER = 1'b1
  } bp_op_e;
endpackage

// File: rtl/bitpack_rst_sync.sv
module bitpack_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bitpack_ctrl.sv
module bitpack_ctrl
  import bitpack_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wide_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             load_o,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NARROW_W - 1);

  bp_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             wide_q, wide_d;
  logic             last;

  assign load_o = start_i && (state_q != ST_RUN);
  assign step_o = (state_q == ST_RUN);
  assign last   = (idx_q == (wide_q ? LAST_WIDE : LAST_NARROW));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    wide_d  = wide_q;
    unique case (state_q)
      ST_RUN: begin
        idx_d = idx_q + 1'b1;
        if (last) state_d = ST_DONE;
      end
      default: begin
        if (load_o) begin
          state_d = ST_RUN;
          idx_d   = '0;
          wide_d  = wide_i;
        end else begin
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wide_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wide_q  <= wide_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign idx_o  = idx_q;
endmodule

// File: rtl/bitpack_datapath.sv
module bitpack_datapath
  import bitpack_pkg::*;
#(
  parameter int DATA_W  = 64,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  bp_op_e            op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] src_q, mask_q, res_q, res_d;
  logic [IDX_W-1:0]  pos_q, pos_d;
  bp_op_e            op_q;
  logic              sel;
  logic [IDX_W-1:0]  rd_idx, wr_idx;

  assign sel    = mask_q[idx_i];
  assign rd_idx = (op_q == OP_GATHER) ? idx_i : pos_q;
  assign wr_idx = (op_q == OP_GATHER) ? pos_q : idx_i;

  always_comb begin
    res_d = res_q;
    pos_d = pos_q;
    if (load_i) begin
      res_d = '0;
      pos_d = '0;
    end else if (step_i && sel) begin
      res_d[wr_idx] = src_q[rd_idx];
      pos_d         = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
      op_q   <= OP_GATHER;
    end else if (load_i) begin
      src_q  <= src_i;
      mask_q <= mask_i;
      op_q   <= op_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      pos_q <= '0;
    end else if (load_i || step_i) begin
      res_q <= res_d;
      pos_q <= pos_d;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/bitpack_unit.sv
module bitpack_unit
  import bitpack_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic              rst_sync_n;
  logic              load, step;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] narrow_keep, keep, src_lim, mask_lim;

  generate
    if (DATA_W > NARROW_W) begin : g_split
      assign narrow_keep = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    end else begin : g_flat
      assign narrow_keep = '1;
    end
  endgenerate

  assign keep     = wide_i ? '1 : narrow_keep;
  assign src_lim  = src_i & keep;
  assign mask_lim = mask_i & keep;

  bitpack_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bitpack_ctrl #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .wide_i  (wide_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load),
    .step_o  (step),
    .idx_o   (idx)
  );

  bitpack_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (load),
    .step_i   (step),
    .op_i     (bp_op_e'(op_i)),
    .src_i    (src_lim),
    .mask_i   (mask_lim),
    .idx_i    (idx),
    .result_o (result_o)
  );
endmodule

// File: rtl/bitpack_unit_chk.sv
module bitpack_unit_chk #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              wide_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o
);
  localparam int CNT_W = $clog2(DATA_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             wide_cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      wide_cap_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      cnt_q      <= '0;
      wide_cap_q <= wide_i;
    end else if (busy_o) begin
      cnt_q      <= cnt_q + 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R3
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy_o && done_o)); // R3
  AST_WALK_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (cnt_q == (wide_cap_q ? CNT_W'(DATA_W) : CNT_W'(NARROW_W)))); // R3
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(result_o)); // R8
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wide_cap_q) |-> (result_o[DATA_W-1:NARROW_W] == '0)); // R6
endmodule

bind bitpack_unit bitpack_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .wide_i   (wide_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/bitpack_unit_tb.sv
module bitpack_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, op, wide;
  logic [63:0] src, mask;
  logic        busy, done;
  logic [63:0] result;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  bitpack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .wide_i(wide),
    .src_i(src), .mask_i(mask), .busy_o(busy), .done_o(done), .result_o(result)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] m_gather(logic [63:0] s, logic [63:0] m, logic w);
    logic [63:0] r = '0;
    int p = 0;
    for (int i = 0; i < (w ? 64 : 32); i++) if (m[i]) begin r[p] = s[i]; p++; end
    return r;
  endfunction

  function automatic logic [63:0] m_scatter(logic [63:0] s, logic [63:0] m, logic w);
    logic [63:0] r = '0;
    int p = 0;
    for (int i = 0; i < (w ? 64 : 32); i++) if (m[i]) begin r[i] = s[p]; p++; end
    return r;
  endfunction

  function automatic logic [63:0] model(logic o, logic [63:0] s, logic [63:0] m, logic w);
    return o ? m_scatter(s, m, w) : m_gather(s, m, w);
  endfunction

  // Runs one operation; if intrude is set, a second start with other operands
  // is fired mid-walk and the inputs are scrambled while busy (R2, R9).
  task automatic run_op(input string tag, input logic o, input logic w,
                        input logic [63:0] s, input logic [63:0] m,
                        input logic intrude, output logic [63:0] res);
    int n = w ? 64 : 32;
    logic lat_ok = 1'b1;
    @(negedge clk);
    start = 1'b1; op = o; wide = w; src = s; mask = m;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (intrude && k == 5) begin
        start = 1'b1; op = ~o; wide = ~w; src = ~s; mask = 64'h0f0f_3c3c_a5a5_ffff;
      end
      if (intrude && k == 6) start = 1'b0;
      if (k < n) begin if (!busy || done) lat_ok = 1'b0; end
      else       begin if (busy || !done) lat_ok = 1'b0; end
    end
    chk({tag, " R3 walk length and done pulse"}, {63'd0, lat_ok}, 64'd1);
    res = result;
    @(negedge clk);
    chk({tag, " R3 done lasts one cycle"}, {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; op = 1'b0; wide = 1'b0; src = '1; mask = '1;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {63'd0, busy}, 64'd0);
    chk("R1 done in reset", {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 result after reset", result, 64'd0);
    chk("R1 busy after reset", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_examples;
    logic [63:0] r;
    run_op("R4 narrow gather example", 1'b0, 1'b0, 64'h0000_0000_1234_5678, 64'h0000_0000_ff00_fff0, 1'b0, r);
    chk("R4 R6 gather example", r, 64'h0000_0000_0001_2567);
    run_op("R5 narrow scatter example", 1'b1, 1'b0, 64'h0000_0000_0001_2567, 64'h0000_0000_ff00_fff0, 1'b0, r);
    chk("R5 R6 scatter example", r, 64'h0000_0000_1200_5670);
    run_op("R6 narrow upper junk", 1'b0, 1'b0, 64'hdead_beef_1234_5678, 64'hffff_ffff_ff00_fff0, 1'b0, r);
    chk("R6 gather ignores upper half", r, 64'h0000_0000_0001_2567);
    run_op("R6 narrow scatter upper junk", 1'b1, 1'b0, 64'hffff_ffff_0001_2567, 64'hffff_ffff_ff00_fff0, 1'b0, r);
    chk("R6 scatter ignores upper half", r, 64'h0000_0000_1200_5670);
  endtask

  task automatic t_wide;
    logic [63:0] r;
    logic [63:0] s_l [4] = '{64'h0123_4567_89ab_cdef, 64'hf0e1_d2c3_b4a5_9687, 64'h8000_0000_0000_0001, 64'h5555_aaaa_3333_cccc};
    logic [63:0] m_l [4] = '{64'hff00_ff00_0f0f_0f0f, 64'h8000_0000_0000_0001, 64'hfffe_0000_0001_ffff, 64'h1248_8421_f00f_0ff0};
    for (int i = 0; i < 4; i++) begin
      run_op("R4 wide gather", 1'b0, 1'b1, s_l[i], m_l[i], 1'b0, r);
      chk("R4 wide gather value", r, model(1'b0, s_l[i], m_l[i], 1'b1));
      run_op("R5 wide scatter", 1'b1, 1'b1, s_l[i], m_l[i], 1'b0, r);
      chk("R5 wide scatter value", r, model(1'b1, s_l[i], m_l[i], 1'b1));
    end
  endtask

  task automatic t_masks;
    logic [63:0] r;
    logic [63:0] s = 64'hcafe_f00d_8badf_00d;
    for (int w = 0; w < 2; w++) begin
      for (int o = 0; o < 2; o++) begin
        run_op("R7 zero mask", o[0], w[0], s, 64'd0, 1'b0, r);
        chk("R7 zero mask gives zero", r, 64'd0);
        run_op("R7 full mask", o[0], w[0], s, '1, 1'b0, r);
        chk("R7 full mask gives source", r, w ? s : {32'd0, s[31:0]});
      end
    end
  endtask

  task automatic t_intrude;
    logic [63:0] r;
    logic [63:0] s = 64'h1357_9bdf_2468_ace0;
    logic [63:0] m = 64'h00ff_ff00_f0f0_3333;
    run_op("R2 R9 wide start while busy", 1'b0, 1'b1, s, m, 1'b1, r);
    chk("R2 R9 wide result unaffected", r, model(1'b0, s, m, 1'b1));
    run_op("R2 R9 narrow start while busy", 1'b1, 1'b0, s, m, 1'b1, r);
    chk("R2 R9 narrow result unaffected", r, model(1'b1, s, m, 1'b0));
  endtask

  task automatic t_hold;
    logic [63:0] r;
    logic stable_ok = 1'b1;
    run_op("R8 setup", 1'b1, 1'b1, 64'h0000_0000_ffff_abcd, 64'haaaa_aaaa_aaaa_aaaa, 1'b0, r);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      src = {src[62:0], src[63]} ^ 64'h9e37; mask = ~mask; op = ~op; wide = ~wide;
      if (result !== r || busy || done) stable_ok = 1'b0;
    end
    chk("R8 result held while idle", {63'd0, stable_ok}, 64'd1);
    chk("R8 held value", result, model(1'b1, 64'h0000_0000_ffff_abcd, 64'haaaa_aaaa_aaaa_aaaa, 1'b1));
  endtask

  task automatic t_mid_reset;
    logic [63:0] r;
    @(negedge clk);
    start = 1'b1; op = 1'b0; wide = 1'b1; src = '1; mask = '1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy cleared by reset", {63'd0, busy}, 64'd0);
    chk("R1 result cleared by reset", result, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done low after reset", {63'd0, done}, 64'd0);
    run_op("R4 after reset", 1'b0, 1'b0, 64'h0000_0000_0000_00f0, 64'h0000_0000_0000_00f0, 1'b0, r);
    chk("R4 gather after reset", r, 64'h0000_0000_0000_000f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_examples();
    t_wide();
    t_masks();
    t_intrude();
    t_hold();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule